// File: doc/BRIEF.md
# Compare-and-Branch Control Unit

This unit computes the next instruction pointer for a small processor whose code, data and stack are separate memories. Each cycle it may receive one decoded control operation, together with an immediate value, a register value, a left-hand compare operand and the address of the instruction that follows in sequence. From these it updates the instruction pointer, the single return-pointer register and two comparison flags. The flags live between instructions, so a conditional jump tests the outcome of the most recent compare.

A call does not use a stack. It saves its link in one dedicated register, so a nested call overwrites the earlier link. A halt freezes the unit until reset. Fetch, decode, the ALU and the register file sit outside this block. Every target is an index into code space only.

Top module: `branch_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ip`, `rp`, `flag_zero`, `flag_above` and `halted` all become zero.
- R2: When `op_valid` is low, no state changes. With `op_valid` high, a no-op (code 0) sets `ip` to `seq_addr`, and codes 12 to 15 do the same.
- R3: An unconditional jump (code 1) loads `ip` with the target. The target is `reg_val` when `use_reg` is 1 and `imm_val` when it is 0, zero-extended or truncated to the pointer width.
- R4: A call (code 6) writes `seq_addr` into `rp` and loads the target into `ip`. Only a call changes `rp`, and a second call overwrites the saved link.
- R5: A return (code 7) loads `ip` with the current `rp` and leaves `rp` unchanged, so two returns in a row reach the same address.
- R6: A compare sets `flag_zero` to (lhs == rhs) and `flag_above` to (lhs > rhs, unsigned), and sets `ip` to `seq_addr`. The right-hand operand depends on the code: the low 8 bits of `imm_val` zero-extended for code 9, the whole of `imm_val` for code 10, and `reg_val` for code 11. No other operation changes the flags.
- R7: The conditional jumps are code 2 (taken when above), code 3 (taken when not above), code 4 (taken when zero) and code 5 (taken when not zero). When taken, `ip` gets the target chosen as in R3. When not taken, `ip` gets `seq_addr`.
- R8: A halt (code 8) sets `halted` and keeps `ip` unchanged. While `halted` is 1, every operation is ignored and all outputs hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 4 | Decoded control operation (codes in R2 to R8) |
| use_reg | input | 1 | Jump or call target comes from `reg_val` |
| imm_val | input | 16 | Immediate target or compare operand |
| reg_val | input | 16 | Register target or compare operand |
| cmp_lhs | input | 16 | Left-hand compare operand |
| seq_addr | input | 16 | Address of the following instruction |
| ip | output | 16 | Current instruction pointer |
| rp | output | 16 | Return pointer |
| flag_zero | output | 1 | Last compare found equal operands |
| flag_above | output | 1 | Last compare found lhs above rhs |
| halted | output | 1 | Execution stopped |

## Verification
The flag update and the flag use meet when a conditional jump arrives in the cycle right after a compare. The jump must act on the flags just written, not on older ones. A call followed at once by a return makes the same demand of the return pointer. Random streams issue compares, jumps, calls and returns back to back with no idle cycles between them. Directed sequences force a compare-then-jump and a call-then-return pair. A bench model advanced on the same edges predicts every output, and the outputs are compared in the middle of each following cycle.

// File: rtl/branch_pkg.sv
// Package: shared operation codes and compare modes for the branch unit.
// Assumes a 4-bit operation field supplied by an external decoder.
package branch_pkg;

    typedef enum logic [3:0] {
        BOP_NOP  = 4'd0,
        BOP_JMP  = 4'd1,
        BOP_JA   = 4'd2,
        BOP_JBE  = 4'd3,
        BOP_JE   = 4'd4,
        BOP_JNE  = 4'd5,
        BOP_CALL = 4'd6,
        BOP_RET  = 4'd7,
        BOP_HALT = 4'd8,
        BOP_CMPB = 4'd9,
        BOP_CMPW = 4'd10,
        BOP_CMPR = 4'd11
    } bop_e;

    typedef enum logic [1:0] {
        CMP_BYTE = 2'd0,
        CMP_WORD = 2'd1,
        CMP_REG  = 2'd2
    } cmp_mode_e;

endpackage

// File: rtl/branch_flags.sv
// Module: compare stage and flag register.
// Chooses the right-hand operand by compare mode, compares without sign,
// and keeps zero/above until the next update. Assumes BYTE_W < DW.
module branch_flags
    import branch_pkg::*;
#(
    parameter int DW     = 16,
    parameter int BYTE_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  cmp_mode_e     mode,
    input  logic [DW-1:0] lhs,
    input  logic [DW-1:0] imm,
    input  logic [DW-1:0] regv,
    output logic          zero_q,
    output logic          above_q
);

    localparam int PAD_W = DW - BYTE_W;

    logic [DW-1:0] rhs;

    // Select the right-hand operand for the active compare form.
    always_comb begin
        unique case (mode)
            CMP_BYTE: rhs = {{PAD_W{1'b0}}, imm[BYTE_W-1:0]};
            CMP_WORD: rhs = imm;
            default:  rhs = regv;
        endcase
    end

    // Flag register: cleared on reset, loaded only on a compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_q  <= 1'b0;
            above_q <= 1'b0;
        end else if (upd) begin
            zero_q  <= (lhs == rhs);
            above_q <= (lhs > rhs);
        end
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(zero_q && above_q)); // R6
    AST_FLAGS_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(zero_q) && $stable(above_q))); // R6

endmodule

// File: rtl/branch_cond.sv
// Module: conditional-jump evaluator.
// Purely combinational. It flags a conditional operation and says whether
// that operation is taken, given the stored flags.
module branch_cond
    import branch_pkg::*;
(
    input  bop_e op,
    input  logic zero,
    input  logic above,
    output logic is_cond,
    output logic taken
);

    // Map each conditional code to its flag test.
    always_comb begin
        is_cond = 1'b1;
        taken   = 1'b0;
        unique case (op)
            BOP_JA:  taken = above;
            BOP_JBE: taken = !above;
            BOP_JE:  taken = zero;
            BOP_JNE: taken = !zero;
            default: is_cond = 1'b0;
        endcase
    end

endmodule

// File: rtl/branch_link.sv
// Module: single return-pointer register.
// Loads the link on a call. There is no stack, so a later call overwrites it.
module branch_link #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save,
    input  logic [AW-1:0] link_in,
    output logic [AW-1:0] rp_q
);

    // Link register: cleared on reset, written only by a call.
    always_ff @(posedge clk) begin
        if (!rst_n)    rp_q <= '0;
        else if (save) rp_q <= link_in;
    end

    AST_RP_ONLY_ON_CALL: assert property (@(posedge clk) disable iff (!rst_n)
        !save |=> $stable(rp_q)); // R4
    AST_RP_LOADS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        save |=> (rp_q == $past(link_in))); // R4

endmodule

// File: rtl/branch_unit.sv
// Module: next-instruction-pointer control for a split code/data machine.
// Holds the IP, the halt state and the flags, and sits on top of the
// compare, condition and link submodules. Assumes one operation per cycle,
// qualified by op_valid.
module branch_unit
    import branch_pkg::*;
#(
    parameter int IP_W   = 16,
    parameter int DW     = 16,
    parameter int BYTE_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic            use_reg,
    input  logic [DW-1:0]   imm_val,
    input  logic [DW-1:0]   reg_val,
    input  logic [DW-1:0]   cmp_lhs,
    input  logic [IP_W-1:0] seq_addr,
    output logic [IP_W-1:0] ip,
    output logic [IP_W-1:0] rp,
    output logic            flag_zero,
    output logic            flag_above,
    output logic            halted
);

    bop_e            op;
    logic            live;
    logic [IP_W-1:0] imm_tgt;
    logic [IP_W-1:0] reg_tgt;
    logic [IP_W-1:0] target;
    logic [IP_W-1:0] ip_d;
    logic            halt_d;
    logic            rp_save;
    logic            flag_upd;
    cmp_mode_e       cmp_mode;
    logic            is_cond;
    logic            cond_taken;

    assign op   = bop_e'(op_code);
    assign live = op_valid && !halted;

    // Fit the data-width targets to the pointer width.
    generate
        if (DW >= IP_W) begin : g_trunc
            assign imm_tgt = imm_val[IP_W-1:0];
            assign reg_tgt = reg_val[IP_W-1:0];
        end else begin : g_zext
            assign imm_tgt = {{(IP_W-DW){1'b0}}, imm_val};
            assign reg_tgt = {{(IP_W-DW){1'b0}}, reg_val};
        end
    endgenerate

    assign target = use_reg ? reg_tgt : imm_tgt;

    branch_cond u_cond (
        .op      (op),
        .zero    (flag_zero),
        .above   (flag_above),
        .is_cond (is_cond),
        .taken   (cond_taken)
    );

    // Decode the operation into the next IP and the side effects.
    always_comb begin
        ip_d     = ip;
        halt_d   = halted;
        rp_save  = 1'b0;
        flag_upd = 1'b0;
        cmp_mode = CMP_REG;
        if (live) begin
            ip_d = seq_addr;
            unique case (op)
                BOP_JMP:  ip_d = target;
                BOP_CALL: begin
                    ip_d    = target;
                    rp_save = 1'b1;
                end
                BOP_RET:  ip_d = rp;
                BOP_HALT: begin
                    ip_d   = ip;
                    halt_d = 1'b1;
                end
                BOP_CMPB: begin
                    flag_upd = 1'b1;
                    cmp_mode = CMP_BYTE;
                end
                BOP_CMPW: begin
                    flag_upd = 1'b1;
                    cmp_mode = CMP_WORD;
                end
                BOP_CMPR: flag_upd = 1'b1;
                default: begin
                    if (is_cond && cond_taken) ip_d = target;
                end
            endcase
        end
    end

    // IP and halt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip     <= '0;
            halted <= 1'b0;
        end else begin
            ip     <= ip_d;
            halted <= halt_d;
        end
    end

    branch_link #(.AW(IP_W)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .save    (rp_save),
        .link_in (seq_addr),
        .rp_q    (rp)
    );

    branch_flags #(.DW(DW), .BYTE_W(BYTE_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (flag_upd),
        .mode    (cmp_mode),
        .lhs     (cmp_lhs),
        .imm     (imm_val),
        .regv    (reg_val),
        .zero_q  (flag_zero),
        .above_q (flag_above)
    );

    AST_HALT_FREEZES_IP: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(ip) && halted)); // R8
    AST_IDLE_HOLDS_IP: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(ip)); // R2
    AST_RET_USES_RP: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == BOP_RET) |=> (ip == $past(rp))); // R5
    AST_CALL_JUMPS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && op == BOP_CALL) |=> (ip == $past(target))); // R4
    AST_CMP_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (live && flag_upd) |=> (ip == $past(seq_addr))); // R6

endmodule

// File: tb/sim_branch_unit.sv
module sim_branch_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_code;
    logic        use_reg;
    logic [15:0] imm_val, reg_val, cmp_lhs, seq_addr;
    logic [15:0] ip, rp;
    logic        flag_zero, flag_above, halted;

    int n_vec = 0;
    int n_bad = 0;

    logic [15:0] m_ip, m_rp;
    logic        m_z, m_a, m_h;

    always #5 clk = ~clk;

    branch_unit u0 (.*);

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd1:                    return "R3";
            4'd2, 4'd3, 4'd4, 4'd5:  return "R7";
            4'd6:                    return "R4";
            4'd7:                    return "R5";
            4'd8:                    return "R8";
            4'd9, 4'd10, 4'd11:      return "R6";
            default:                 return "R2";
        endcase
    endfunction

    // Model step: next state from the requirements.
    task automatic model_step();
        logic [15:0] tgt, rhs;
        logic take;
        if (!rst_n) begin
            m_ip = 0; m_rp = 0; m_z = 0; m_a = 0; m_h = 0;
        end else if (op_valid && !m_h) begin
            tgt  = use_reg ? reg_val : imm_val;
            take = 1'b0;
            case (op_code)
                4'd2: take = m_a;
                4'd3: take = !m_a;
                4'd4: take = m_z;
                4'd5: take = !m_z;
                default: ;
            endcase
            case (op_code)
                4'd1: m_ip = tgt;
                4'd2, 4'd3, 4'd4, 4'd5: m_ip = take ? tgt : seq_addr;
                4'd6: begin m_rp = seq_addr; m_ip = tgt; end
                4'd7: m_ip = m_rp;
                4'd8: m_h = 1'b1;
                4'd9, 4'd10, 4'd11: begin
                    rhs = (op_code == 4'd9) ? {8'h00, imm_val[7:0]} :
                          (op_code == 4'd10) ? imm_val : reg_val;
                    m_z = (cmp_lhs == rhs);
                    m_a = (cmp_lhs > rhs);
                    m_ip = seq_addr;
                end
                default: m_ip = seq_addr;
            endcase
        end
    endtask

    task automatic check_all(input string req);
        n_vec++;
        if ({ip, rp, flag_zero, flag_above, halted} !==
            {m_ip, m_rp, m_z, m_a, m_h}) begin
            n_bad++;
            $display("FAIL %s: ip=%h rp=%h z=%b a=%b h=%b expected ip=%h rp=%h z=%b a=%b h=%b",
                     req, ip, rp, flag_zero, flag_above, halted,
                     m_ip, m_rp, m_z, m_a, m_h);
        end
    endtask

    // Apply one cycle: inputs set off the edge, model advanced, checked mid-cycle.
    task automatic apply(input logic v, input logic [3:0] c, input logic ur,
                         input logic [15:0] im, input logic [15:0] rv,
                         input logic [15:0] lh, input logic [15:0] sq);
        string tag;
        op_valid = v; op_code = c; use_reg = ur;
        imm_val = im; reg_val = rv; cmp_lhs = lh; seq_addr = sq;
        tag = !rst_n ? "R1" : (!v ? "R2" : (m_h ? "R8" : req_of(c)));
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin : watchdog
        #1500000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        m_ip = 16'hx; m_rp = 16'hx;
        @(negedge clk);
        apply(1, 4'd1, 0, 16'h1234, 0, 0, 0);   // R1 reset wins over jump
        rst_n = 1'b1;
        // R2 idle, then no-op
        apply(0, 4'd1, 0, 16'hBEEF, 0, 0, 16'h0004);
        apply(1, 4'd0, 0, 16'hBEEF, 0, 0, 16'h0004);
        apply(1, 4'd13, 0, 16'hBEEF, 0, 0, 16'h0009);
        // R3 both target sources
        apply(1, 4'd1, 0, 16'h0100, 16'h0200, 0, 16'h000A);
        apply(1, 4'd1, 1, 16'h0100, 16'h0200, 0, 16'h000A);
        // R6 byte compare ignores upper immediate bits, then R7 right after it
        apply(1, 4'd9, 0, 16'hFF12, 0, 16'h0012, 16'h0201);
        apply(1, 4'd4, 0, 16'h0300, 0, 0, 16'h0202);
        apply(1, 4'd10, 0, 16'hFF12, 0, 16'h0012, 16'h0301);
        apply(1, 4'd3, 1, 0, 16'h0400, 0, 16'h0302);
        apply(1, 4'd11, 0, 0, 16'h0005, 16'h0009, 16'h0401);
        apply(1, 4'd2, 0, 16'h0500, 0, 0, 16'h0402);
        apply(1, 4'd4, 0, 16'h0600, 0, 0, 16'h0501);
        // R4 nested call overwrites, R5 two returns reach the same place
        apply(1, 4'd6, 0, 16'h0700, 0, 0, 16'h0503);
        apply(1, 4'd6, 1, 0, 16'h0800, 0, 16'h0701);
        apply(1, 4'd7, 0, 0, 0, 0, 16'h0801);
        apply(1, 4'd7, 0, 0, 0, 0, 16'h0702);
        // R8 halt then ignored operations
        apply(1, 4'd8, 0, 0, 0, 0, 16'h0703);
        apply(1, 4'd6, 0, 16'h0999, 0, 0, 16'h0704);
        apply(1, 4'd9, 0, 16'h0000, 0, 16'h0000, 16'h0705);
        rst_n = 1'b0;
        apply(1, 4'd0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        // Random stream, back-to-back, with occasional halt and reset
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] c;
            c = 4'($urandom_range(0, 15));
            if (c == 4'd8 && ($urandom % 6) != 0) c = 4'd0;
            if (m_h && ($urandom % 4) == 0) rst_n = 1'b0;
            apply(($urandom % 8) != 0, c, 1'($urandom % 2),
                  16'($urandom % 24), 16'($urandom % 24),
                  16'($urandom % 24), 16'($urandom));
            rst_n = 1'b1;
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule